// File: doc/BRIEF.md
# Soft-Start and Overcurrent Latch-Off Sequencer

This block sequences a regulator's power-up and its response to overcurrent. A programmable digital timer takes the place of an external delay capacitor. The same block produces the soft-start reference ramp and measures the latch-off delay. The regulator runs only when enable is high and undervoltage lockout has cleared. In that case the block raises its reference ramp one code at a time until full scale, then holds it.

A current-limit flag does not stop the regulator at once. The block keeps the regulator switching and freezes the ramp. It counts down a programmable latch-off delay while the current limit stays active. If the limit is still active when the count runs out, the regulator stops and a fault latches. If the limit clears in time, recovery depends on the output. An output inside its power-good window returns to normal running. An output that has collapsed restarts the soft-start ramp from zero.

A latched fault is cleared only by dropping enable or by a lockout event. A configuration input can disable the latch-off action entirely.

Top module: `sslo_ctrl`

## Requirements
- R1: Within one clock of enable being low or lockout being high, in any state, `ramp_o` is 0 and `run_o` and `fault_o` are both 0. These values hold while the condition lasts.
- R2: At the first clock edge that sees enable high and lockout low, `run_o` goes to 1 and the ramp starts at 0. The ramp then rises by one code every `ss_div_i`+1 clocks.
- R3: The ramp stops at full scale, 2^RAMP_W-1, and stays there while the regulator runs without current limit.
- R4: A current-limit flag seen while ramping or running keeps `run_o` at 1 and `fault_o` at 0. It freezes the ramp and loads the latch-off timer with `lo_dly_i`.
- R5: If the current limit persists, the latch occurs at the (`lo_dly_i`+1)-th clock edge after the entry edge. Then `fault_o` becomes 1, `run_o` becomes 0 and `ramp_o` becomes 0.
- R6: If the current limit clears before the latch and `pgood_i` is 1, normal running resumes with the ramp at full scale and no fault.
- R7: If the current limit clears before the latch and `pgood_i` is 0 while `vlow_i` is 1, the ramp drops to 0 and a new soft-start begins. `pgood_i` has priority over `vlow_i`.
- R8: If the current limit clears while both `pgood_i` and `vlow_i` are 0, the block keeps waiting. The timer pauses without reloading and resumes its count if the limit returns.
- R9: In the latched state, the current-limit, power-good and low-output flags have no effect. Only R1's conditions leave it.
- R10: While `latch_dis_i` is 1, a persisting current limit never latches a fault, and the regulator keeps running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Regulator enable |
| uvlo_i | input | 1 | Undervoltage lockout active |
| ilim_i | input | 1 | Current limit reached |
| pgood_i | input | 1 | Output within power-good window |
| vlow_i | input | 1 | Output below power-good threshold |
| latch_dis_i | input | 1 | Disable latch-off |
| ss_div_i | input | DIV_W | Clocks per ramp step, minus one |
| lo_dly_i | input | DLY_W | Latch-off delay count |
| ramp_o | output | RAMP_W | Soft-start reference ramp |
| run_o | output | 1 | Regulator switching enable |
| fault_o | output | 1 | Latched overcurrent fault |

## Verification
The bench builds the block with RAMP_W=4, DIV_W=4 and DLY_W=6. With these sizes a full soft-start takes 15 steps, so complete ramps, restarts and re-ramps after a cleared latch all fit in a few dozen cycles each. Step dividers of 0 and 2 and latch delays of 0 and 5 exercise the exact edge at which the ramp reaches full scale and the exact edge at which the latch occurs. The short delay also lets a paused-then-resumed count be followed edge by edge.

// File: rtl/sslo_pkg.sv
package sslo_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_SOFT  = 3'd1,
    ST_RUN   = 3'd2,
    ST_OCW   = 3'd3,
    ST_LATCH = 3'd4
  } sslo_state_e;
endpackage

// File: rtl/sslo_timer.sv
module sslo_timer #(
  parameter int DLY_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic             dec_i,
  input  logic [DLY_W-1:0] value_i,
  output logic             zero_o
);
  logic [DLY_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= value_i;
    end else if (dec_i && cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign zero_o = (cnt_q == '0);

  // R8
  tmr_no_rise_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(load_i) |-> cnt_q <= $past(cnt_q));
endmodule

// File: rtl/sslo_ramp.sv
module sslo_ramp #(
  parameter int RAMP_W = 8,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr_i,
  input  logic              fill_i,
  input  logic              step_i,
  input  logic [DIV_W-1:0]  div_i,
  output logic [RAMP_W-1:0] ramp_o,
  output logic              full_o
);
  localparam logic [RAMP_W-1:0] RAMP_MAX = '1;

  logic [RAMP_W-1:0] ramp_q;
  logic [DIV_W-1:0]  pre_q;

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      ramp_q <= '0;
      pre_q  <= '0;
    end else if (fill_i) begin
      ramp_q <= RAMP_MAX;
      pre_q  <= '0;
    end else if (step_i) begin
      if (pre_q == div_i) begin
        pre_q <= '0;
        if (ramp_q != RAMP_MAX) ramp_q <= ramp_q + 1'b1;
      end else begin
        pre_q <= pre_q + 1'b1;
      end
    end
  end

  assign ramp_o = ramp_q;
  assign full_o = (ramp_q == RAMP_MAX);

  // R2
  ramp_single_step_chk: assert property (@(posedge clk) disable iff (rst)
    (ramp_q != $past(ramp_q)) |->
      (ramp_q == '0 || ramp_q == RAMP_MAX || ramp_q == RAMP_W'($past(ramp_q) + 1'b1)));
endmodule

// File: rtl/sslo_fsm.sv
module sslo_fsm
  import sslo_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic go_i,
  input  logic ilim_i,
  input  logic pgood_i,
  input  logic vlow_i,
  input  logic latch_dis_i,
  input  logic ramp_full_i,
  input  logic tmr_zero_i,
  output logic tmr_load_o,
  output logic tmr_dec_o,
  output logic ramp_clr_o,
  output logic ramp_fill_o,
  output logic ramp_step_o,
  output logic run_o,
  output logic fault_o
);
  sslo_state_e st_q, st_d;
  logic run_q, fault_q;

  always_comb begin
    st_d = st_q;
    if (!go_i) begin
      st_d = ST_IDLE;
    end else begin
      case (st_q)
        ST_IDLE: st_d = ST_SOFT;
        ST_SOFT: begin
          if (ilim_i)           st_d = ST_OCW;
          else if (ramp_full_i) st_d = ST_RUN;
        end
        ST_RUN:  if (ilim_i) st_d = ST_OCW;
        ST_OCW: begin
          if (ilim_i) begin
            if (tmr_zero_i && !latch_dis_i) st_d = ST_LATCH;
          end else if (pgood_i) begin
            st_d = ST_RUN;
          end else if (vlow_i) begin
            st_d = ST_SOFT;
          end
        end
        ST_LATCH: st_d = ST_LATCH;
        default:  st_d = ST_IDLE;
      endcase
    end
  end

  always_comb begin
    tmr_load_o  = (st_q == ST_SOFT || st_q == ST_RUN) && st_d == ST_OCW;
    tmr_dec_o   = (st_q == ST_OCW) && ilim_i && !tmr_zero_i;
    ramp_clr_o  = (st_d == ST_IDLE) || (st_d == ST_LATCH) ||
                  (st_q == ST_OCW && st_d == ST_SOFT);
    ramp_fill_o = (st_q == ST_OCW) && (st_d == ST_RUN);
    ramp_step_o = (st_q == ST_SOFT) && (st_d == ST_SOFT);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_IDLE;
      run_q   <= 1'b0;
      fault_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      run_q   <= (st_d == ST_SOFT) || (st_d == ST_RUN) || (st_d == ST_OCW);
      fault_q <= (st_d == ST_LATCH);
    end
  end

  assign run_o   = run_q;
  assign fault_o = fault_q;

  // R9
  latch_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(fault_q) && $past(go_i)) |-> fault_q);

  // R10
  latch_disabled_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(fault_q) && $past(latch_dis_i)) |-> !fault_q);
endmodule

// File: rtl/sslo_ctrl.sv
module sslo_ctrl #(
  parameter int RAMP_W = 8,
  parameter int DIV_W  = 8,
  parameter int DLY_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en_i,
  input  logic              uvlo_i,
  input  logic              ilim_i,
  input  logic              pgood_i,
  input  logic              vlow_i,
  input  logic              latch_dis_i,
  input  logic [DIV_W-1:0]  ss_div_i,
  input  logic [DLY_W-1:0]  lo_dly_i,
  output logic [RAMP_W-1:0] ramp_o,
  output logic              run_o,
  output logic              fault_o
);
  logic go;
  logic tmr_load, tmr_dec, tmr_zero;
  logic ramp_clr, ramp_fill, ramp_step, ramp_full;

  assign go = en_i && !uvlo_i;

  sslo_fsm u_fsm (
    .clk         (clk),
    .rst         (rst),
    .go_i        (go),
    .ilim_i      (ilim_i),
    .pgood_i     (pgood_i),
    .vlow_i      (vlow_i),
    .latch_dis_i (latch_dis_i),
    .ramp_full_i (ramp_full),
    .tmr_zero_i  (tmr_zero),
    .tmr_load_o  (tmr_load),
    .tmr_dec_o   (tmr_dec),
    .ramp_clr_o  (ramp_clr),
    .ramp_fill_o (ramp_fill),
    .ramp_step_o (ramp_step),
    .run_o       (run_o),
    .fault_o     (fault_o)
  );

  sslo_timer #(.DLY_W(DLY_W)) u_tmr (
    .clk     (clk),
    .rst     (rst),
    .load_i  (tmr_load),
    .dec_i   (tmr_dec),
    .value_i (lo_dly_i),
    .zero_o  (tmr_zero)
  );

  sslo_ramp #(.RAMP_W(RAMP_W), .DIV_W(DIV_W)) u_ramp (
    .clk    (clk),
    .rst    (rst),
    .clr_i  (ramp_clr),
    .fill_i (ramp_fill),
    .step_i (ramp_step),
    .div_i  (ss_div_i),
    .ramp_o (ramp_o),
    .full_o (ramp_full)
  );

  // R1
  off_forces_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(en_i) || $past(uvlo_i)) |-> (ramp_o == '0 && !run_o && !fault_o));

  // R5
  fault_stops_chk: assert property (@(posedge clk) disable iff (rst)
    fault_o |-> (!run_o && ramp_o == '0));
endmodule

// File: tb/sslo_ctrl_tb.sv
module sslo_ctrl_tb;
  localparam int RW = 4;
  localparam int DW = 4;
  localparam int LW = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 1'b0, uvlo = 1'b0, ilim = 1'b0, pgood = 1'b0, vlow = 1'b0, ldis = 1'b0;
  logic [DW-1:0] sdiv = '0;
  logic [LW-1:0] ldly = '0;
  logic [RW-1:0] ramp;
  logic run, fault;

  int checks = 0;
  int fails  = 0;
  int exp_q[$];
  int last_ramp = 0;

  always #2.5 clk = ~clk;

  sslo_ctrl #(.RAMP_W(RW), .DIV_W(DW), .DLY_W(LW)) u_dut (
    .clk(clk), .rst(rst), .en_i(en), .uvlo_i(uvlo), .ilim_i(ilim),
    .pgood_i(pgood), .vlow_i(vlow), .latch_dis_i(ldis),
    .ss_div_i(sdiv), .lo_dly_i(ldly),
    .ramp_o(ramp), .run_o(run), .fault_o(fault)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic push_ramp_up();
    for (int k = 1; k < (1 << RW); k++) exp_q.push_back(k);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_out(input string req, input int r, input int ru, input int f);
    chk({req, " ramp"}, int'(ramp), r);
    chk({req, " run"}, int'(run), ru);
    chk({req, " fault"}, int'(fault), f);
  endtask

  // scoreboard monitor: every ramp change must match the next expected item
  always @(negedge clk) begin
    if (!rst && int'(ramp) != last_ramp) begin
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R2 ramp sequence: actual %0d expected no change", ramp);
      end else begin
        int e;
        e = exp_q.pop_front();
        if (int'(ramp) != e) begin
          fails++;
          $display("FAIL R2 ramp sequence: actual %0d expected %0d", ramp, e);
        end
      end
      last_ramp = int'(ramp);
    end
  end

  initial begin
    #2_000_000;
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    tick(4);
    rst = 1'b0;
    tick(2);
    chk_out("R1 reset", 0, 0, 0);

    // R2/R3: soft-start with a three-clock step
    sdiv = 4'd2;
    push_ramp_up();
    en = 1'b1;
    tick(1);
    chk_out("R2 start", 0, 1, 0);
    tick(44);
    chk("R2 ramp at edge 45", int'(ramp), 14);
    tick(1);
    chk("R3 full scale at edge 46", int'(ramp), 15);
    tick(10);
    chk_out("R3 hold", 15, 1, 0);

    // R4/R6: limit then clear inside power-good window
    ldly = 6'd5;
    ilim = 1'b1;
    tick(1);
    chk_out("R4 entry", 15, 1, 0);
    tick(3);
    ilim = 1'b0; pgood = 1'b1;
    tick(2);
    chk_out("R6 resume", 15, 1, 0);
    tick(8);
    chk_out("R6 stays", 15, 1, 0);

    // R7: limit then clear with collapsed output
    pgood = 1'b0; vlow = 1'b1;
    ilim = 1'b1;
    tick(2);
    ilim = 1'b0;
    exp_q.push_back(0);
    tick(1);
    chk_out("R7 restart", 0, 1, 0);
    push_ramp_up();
    vlow = 1'b0;
    tick(45);
    chk("R7 re-ramp full", int'(ramp), 15);
    tick(2);

    // R8: pause without reload
    ilim = 1'b1;
    tick(3);
    ilim = 1'b0;
    tick(3);
    chk_out("R8 waiting", 15, 1, 0);
    ilim = 1'b1;
    tick(3);
    chk_out("R8 resumed count", 15, 1, 0);
    exp_q.push_back(0);
    tick(1);
    chk_out("R8 latch", 0, 0, 1);

    // R9: flags ignored while latched, lockout clears
    ilim = 1'b0; pgood = 1'b1; vlow = 1'b1;
    tick(5);
    chk_out("R9 ignored", 0, 0, 1);
    pgood = 1'b0; vlow = 1'b0;
    uvlo = 1'b1;
    tick(1);
    chk_out("R9 lockout clear", 0, 0, 0);
    tick(3);
    chk_out("R1 held in lockout", 0, 0, 0);
    sdiv = 4'd0;
    push_ramp_up();
    uvlo = 1'b0;
    tick(1);
    chk("R2 restart run", int'(run), 1);
    tick(15);
    chk("R2 fast ramp full", int'(ramp), 15);
    tick(2);

    // R5: exact latch edge
    ilim = 1'b1;
    tick(1);
    tick(5);
    chk_out("R5 before expiry", 15, 1, 0);
    exp_q.push_back(0);
    tick(1);
    chk_out("R5 latched", 0, 0, 1);
    ilim = 1'b0;

    // R1/R9: enable low clears latch in one clock
    en = 1'b0;
    tick(1);
    chk_out("R1 enable low", 0, 0, 0);
    en = 1'b1; ldis = 1'b1;
    push_ramp_up();
    tick(16);
    chk("R2 ramp after enable", int'(ramp), 15);
    tick(2);

    // R10: latch-off disabled
    ldly = 6'd0;
    ilim = 1'b1;
    tick(100);
    chk_out("R10 no latch", 15, 1, 0);
    ldis = 1'b0;
    exp_q.push_back(0);
    tick(1);
    chk_out("R10 re-armed latch", 0, 0, 1);
    ilim = 1'b0;

    // R1: lockout from running
    uvlo = 1'b1;
    tick(1);
    uvlo = 1'b0;
    push_ramp_up();
    tick(17);
    chk_out("R2 ramp after lockout", 15, 1, 0);
    exp_q.push_back(0);
    en = 1'b0;
    tick(1);
    chk_out("R1 off from run", 0, 0, 0);
    tick(2);
    chk("R2 scoreboard drained", exp_q.size(), 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule